// File: doc/BRIEF.md
# Segmented Little-Endian Memory Access Unit

This unit turns a segment-relative reference into a 20-bit physical byte address and carries out a byte or word access on a byte-wide store. A request names one of four segment registers with a 2-bit code, gives a 16-bit offset, and says whether it is a byte or a word access and whether it is a read or a write. The unit multiplies the selected segment value by sixteen, adds the offset, keeps the low 20 bits of the sum, and then moves one byte per clock. A word is moved as two byte cycles, with the low-order byte at the lower address.

The segment registers are loaded through their own write port and are cleared by reset. The store covers a 1 MB address space, but only a small array is built. It is indexed by the low `MEM_AW` bits of the physical address, so addresses whose low bits match name the same byte. The client sees a ready level that is high only while the unit is idle. It sees a one-cycle done pulse with the read result, and it can watch the address of each byte transfer.

The control machine has four states. IDLE waits for a request. LOW moves the first byte. HIGH moves the second byte of a word. DONE raises the done pulse. The transitions are IDLE to LOW on an accepted request, LOW to HIGH for a word, LOW to DONE for a byte, HIGH to DONE, and DONE to IDLE.

Top module: `seg_mem_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `rdata` is 0, all four segment registers hold 0, and every stored byte reads as 0.
- R2: When `seg_wr_en` is 1 at a clock edge, `seg_wr_val` is written into the segment register selected by `seg_wr_sel`. The codes are 0 for code, 1 for data, 2 for stack and 3 for extra.
- R3: The physical address of an access is (segment × 16 + offset) mod 2^20, using the register chosen by `req_seg`. The address appears on `xfer_addr`, with `xfer_active` high, in the first cycle after acceptance.
- R4: A request is taken only at an edge where both `req_valid` and `req_ready` are 1. `req_ready` is 1 only in IDLE. A request presented while the unit is busy has no effect.
- R5: A byte access (`req_word`=0) uses one transfer cycle. `done` is 1 in the second cycle after the accepting edge. A byte read returns the byte in `rdata[7:0]` with `rdata[15:8]` = 0.
- R6: A word access uses two transfer cycles. The first is at address A and the second is at (A+1) mod 2^20, so an access at FFFFF continues at 00000. `done` is 1 in the third cycle after the accepting edge.
- R7: A word write stores `req_wdata[7:0]` at A and `req_wdata[15:8]` at A+1. A word read returns the byte at A+1 in `rdata[15:8]` and the byte at A in `rdata[7:0]`.
- R8: `done` lasts exactly one cycle. `rdata` changes only in a cycle where `done` is 1. It holds its value through writes and until the next read completes.
- R9: If a segment register load and the acceptance of a request that uses that register fall on the same edge, the request uses the value held before that edge. Later requests use the new value.
- R10: The store keeps one byte for each value of the low `MEM_AW` (default 8) bits of the physical address. Two physical addresses with the same low bits access the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load enable for a segment register |
| seg_wr_sel | input | 2 | Segment register to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_val | input | 16 | Value to load |
| req_valid | input | 1 | Access request present |
| req_seg | input | 2 | Segment register used by the request |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 for a word access, 0 for a byte access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 16 | Write data (low byte only for byte writes) |
| req_ready | output | 1 | Unit idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid while done is 1 and held afterwards |
| xfer_active | output | 1 | A byte transfer takes place this cycle |
| xfer_addr | output | 20 | Physical address of the current byte transfer |

## Verification
Two functions can fall on the same edge: a segment-register load and the acceptance of a request that reads that register. The bench provokes this by raising `seg_wr_en` for the data segment in the same cycle as a data-segment request. It then checks that the first transfer address comes from the old segment value and that the next request uses the new one. A second overlap is a fresh request offered while a word transfer is still running. That request must leave both the store and the transfer addresses untouched, which a later read of its target confirms. Every cycle is also compared with a behavioural queue model of ready, done, the transfer address and the read data.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_DONE = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 4,
    parameter int SEL_W   = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_val
);

    logic [SEG_W-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                seg_q[g] <= wr_val;
            end
        end
    end

    assign rd_val = seg_q[rd_sel];

    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (seg_q[$past(wr_sel)] == $past(wr_val)));  // R2

endmodule

// File: rtl/phys_addr_gen.sv
module phys_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] off_val,
    input  logic [PA_W-1:0]  base_addr,
    output logic [PA_W-1:0]  phys_addr,
    output logic [PA_W-1:0]  next_addr
);

    localparam int SHIFT = PA_W - SEG_W;

    logic [PA_W-1:0] seg_base;
    logic [PA_W-1:0] off_ext;

    assign seg_base  = {seg_val, {SHIFT{1'b0}}};
    assign off_ext   = PA_W'(off_val);
    assign phys_addr = seg_base + off_ext;
    assign next_addr = base_addr + PA_W'(1);

endmodule

// File: rtl/byte_array.sv
module byte_array #(
    parameter int MEM_AW = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] idx,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[idx] <= wbyte;
        end
    end

    assign rbyte = cells[idx];

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cells[$past(idx)] == $past(wbyte)));  // R7

endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int PA_W    = 20,
    parameter int MEM_AW  = 8,
    parameter int BYTE_W  = 8,
    parameter int NUM_SEG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_wr_en,
    input  logic [1:0]          seg_wr_sel,
    input  logic [SEG_W-1:0]    seg_wr_val,
    input  logic                req_valid,
    input  logic [1:0]          req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                req_word,
    input  logic                req_write,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                done,
    output logic [2*BYTE_W-1:0] rdata,
    output logic                xfer_active,
    output logic [PA_W-1:0]     xfer_addr
);

    import seg_mem_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;

    xfer_state_e state_q, state_d;

    logic [SEG_W-1:0]  seg_val;
    logic [PA_W-1:0]   pa_calc;
    logic [PA_W-1:0]   pa_inc;
    logic [PA_W-1:0]   base_q;
    logic              word_q;
    logic              write_q;
    logic [WORD_W-1:0] wdata_q;
    logic [BYTE_W-1:0] lo_q;
    logic [WORD_W-1:0] rdata_q;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_wbyte;
    logic [BYTE_W-1:0] mem_rbyte;
    logic              accept;

    seg_reg_bank #(
        .SEG_W   (SEG_W),
        .NUM_SEG (NUM_SEG),
        .SEL_W   (2)
    ) u_segs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (seg_wr_en),
        .wr_sel (seg_wr_sel),
        .wr_val (seg_wr_val),
        .rd_sel (req_seg),
        .rd_val (seg_val)
    );

    phys_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W)
    ) u_agen (
        .seg_val   (seg_val),
        .off_val   (req_off),
        .base_addr (base_q),
        .phys_addr (pa_calc),
        .next_addr (pa_inc)
    );

    byte_array #(
        .MEM_AW (MEM_AW),
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (xfer_addr[MEM_AW-1:0]),
        .wbyte (mem_wbyte),
        .rbyte (mem_rbyte)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOW;
            ST_LOW:  state_d = word_q ? ST_HIGH : ST_DONE;
            ST_HIGH: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs per state
    always_comb begin
        req_ready   = 1'b0;
        done        = 1'b0;
        xfer_active = 1'b0;
        xfer_addr   = base_q;
        mem_wbyte   = wdata_q[BYTE_W-1:0];
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOW:  xfer_active = 1'b1;
            ST_HIGH: begin
                xfer_active = 1'b1;
                xfer_addr   = pa_inc;
                mem_wbyte   = wdata_q[WORD_W-1:BYTE_W];
            end
            ST_DONE: done = 1'b1;
        endcase
        mem_we = xfer_active && write_q;
    end

    // request capture and read assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            word_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            lo_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                base_q  <= pa_calc;
                word_q  <= req_word;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_LOW && !write_q) begin
                if (word_q) begin
                    lo_q <= mem_rbyte;
                end else begin
                    rdata_q <= {{BYTE_W{1'b0}}, mem_rbyte};
                end
            end
            if (state_q == ST_HIGH && !write_q) begin
                rdata_q <= {mem_rbyte, lo_q};
            end
        end
    end

    assign rdata = rdata_q;

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!done && !xfer_active));  // R4

    AST_BYTE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && !word_q) |=> done);  // R5

    AST_WORD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && word_q) |=> (xfer_active && (xfer_addr == PA_W'($past(xfer_addr) + 1'b1))));  // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);  // R8

endmodule

// File: tb/seg_mem_unit_test.sv
`timescale 1ns/1ps
module seg_mem_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = 2'd0;
    logic [15:0] seg_wr_val = 16'h0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_seg = 2'd0;
    logic [15:0] req_off = 16'h0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = 16'h0;
    logic        req_ready;
    logic        done;
    logic [15:0] rdata;
    logic        xfer_active;
    logic [19:0] xfer_addr;

    int checks = 0;
    int failures = 0;
    bit running = 1'b0;

    always #2 clk = ~clk;

    seg_mem_unit uut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .xfer_active(xfer_active), .xfer_addr(xfer_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_seg [4];
    logic [7:0]  m_mem [256];
    logic [19:0] m_q [$];
    int          m_stage;
    int          m_k;
    logic        m_write, m_word;
    logic [15:0] m_wdata, m_rdata;
    logic [7:0]  m_lo, m_hi;
    logic [19:0] m_pa, m_a;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
            for (int i = 0; i < 256; i++) m_mem[i] = 8'h0;
            m_q.delete();
            m_stage = 0; m_k = 0; m_rdata = 16'h0;
            m_write = 1'b0; m_word = 1'b0; m_wdata = 16'h0; m_lo = 8'h0; m_hi = 8'h0;
        end else begin
            case (m_stage)
                0: if (req_valid) begin
                    m_pa = 20'({m_seg[req_seg], 4'h0}) + 20'(req_off);
                    m_q.push_back(m_pa);
                    if (req_word) m_q.push_back(m_pa + 20'd1);
                    m_write = req_write; m_word = req_word; m_wdata = req_wdata;
                    m_k = 0; m_stage = 1;
                end
                1: begin
                    m_a = m_q.pop_front();
                    if (m_write) m_mem[m_a[7:0]] = (m_k == 0) ? m_wdata[7:0] : m_wdata[15:8];
                    else if (m_k == 0) m_lo = m_mem[m_a[7:0]];
                    else m_hi = m_mem[m_a[7:0]];
                    m_k++;
                    if (m_q.size() == 0) begin
                        if (!m_write) m_rdata = m_word ? {m_hi, m_lo} : {8'h0, m_lo};
                        m_stage = 2;
                    end
                end
                default: m_stage = 0;
            endcase
            if (seg_wr_en) m_seg[seg_wr_sel] = seg_wr_val;
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            chk("R4 ready", {31'h0, req_ready}, {31'h0, m_stage == 0});
            chk("R8 done", {31'h0, done}, {31'h0, m_stage == 2});
            chk("R5 active", {31'h0, xfer_active}, {31'h0, m_stage == 1});
            if (m_stage == 1) chk("R3/R6 addr", {12'h0, xfer_addr}, {12'h0, m_q[0]});
            chk("R7 rdata", {16'h0, rdata}, {16'h0, m_rdata});
        end
    end

    task automatic load_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_val = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] r);
        int n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        r = rdata;
    endtask

    task automatic do_req(input logic [1:0] s, input logic [15:0] o, input logic w,
                          input logic wr, input logic [15:0] d,
                          output logic [15:0] r, output logic [19:0] fa);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_word = w; req_write = wr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        fa = xfer_addr;
        wait_done(r);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        logic [19:0] fa;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 rdata", {16'h0, rdata}, 32'h0);

        // R1: segments at zero, store cleared
        do_req(2'd0, 16'h0040, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R1 seg zero addr", {12'h0, fa}, 32'h00040);
        chk("R1 store zero", {16'h0, r}, 32'h0);

        // R2 R3 R5: data segment byte write/read
        load_seg(2'd1, 16'h027A);
        do_req(2'd1, 16'h0017, 1'b0, 1'b1, 16'h00AB, r, fa);
        chk("R3 addr 027B7", {12'h0, fa}, 32'h027B7);
        do_req(2'd1, 16'h0017, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R5 byte read", {16'h0, r}, 32'h00AB);

        // R7: little-endian word via stack segment
        load_seg(2'd2, 16'h3146);
        do_req(2'd2, 16'h1500, 1'b1, 1'b1, 16'h35F3, r, fa);
        chk("R3 addr 32960", {12'h0, fa}, 32'h32960);
        chk("R8 rdata held over write", {16'h0, r}, 32'h00AB);
        do_req(2'd2, 16'h1500, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R7 low byte", {16'h0, r}, 32'h00F3);
        do_req(2'd2, 16'h1501, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R7 high byte", {16'h0, r}, 32'h0035);
        do_req(2'd2, 16'h1500, 1'b1, 1'b0, 16'h0, r, fa);
        chk("R7 word read", {16'h0, r}, 32'h35F3);

        // R3: wrap at 1 MB
        load_seg(2'd2, 16'hFFFF);
        do_req(2'd2, 16'h0010, 1'b0, 1'b1, 16'h005A, r, fa);
        chk("R3 wrap addr", {12'h0, fa}, 32'h00000);
        do_req(2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R3 wrap data", {16'h0, r}, 32'h005A);

        // R6: word straddling FFFFF -> 00000
        load_seg(2'd3, 16'hF000);
        do_req(2'd3, 16'hFFFF, 1'b1, 1'b1, 16'h1234, r, fa);
        chk("R6 first addr", {12'h0, fa}, 32'hFFFFF);
        do_req(2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R6 wrapped high byte", {16'h0, r}, 32'h0012);
        do_req(2'd3, 16'hFFFF, 1'b1, 1'b0, 16'h0, r, fa);
        chk("R6 word read wrap", {16'h0, r}, 32'h1234);

        // R10: aliasing on low address bits
        load_seg(2'd1, 16'h0000);
        do_req(2'd1, 16'h0105, 1'b0, 1'b1, 16'h00C3, r, fa);
        do_req(2'd0, 16'h0005, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R10 alias", {16'h0, r}, 32'h00C3);

        // R9: segment load coincident with acceptance
        load_seg(2'd1, 16'h0100);
        @(negedge clk);
        req_valid = 1'b1; req_seg = 2'd1; req_off = 16'h0000; req_word = 1'b0; req_write = 1'b0;
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_val = 16'h0200;
        @(negedge clk);
        req_valid = 1'b0; seg_wr_en = 1'b0;
        chk("R9 old segment used", {12'h0, xfer_addr}, 32'h01000);
        wait_done(r);
        do_req(2'd1, 16'h0000, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R9 new segment next", {12'h0, fa}, 32'h02000);

        // R4: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_seg = 2'd1; req_off = 16'h0010; req_word = 1'b1; req_write = 1'b1; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_seg = 2'd0; req_off = 16'h0077; req_word = 1'b0; req_write = 1'b1; req_wdata = 16'h00EE;
        chk("R4 busy not ready", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(r);
        do_req(2'd0, 16'h0077, 1'b0, 1'b0, 16'h0, r, fa);
        chk("R4 busy request ignored", {16'h0, r}, 32'h0000);
        do_req(2'd1, 16'h0010, 1'b1, 1'b0, 16'h0, r, fa);
        chk("R7 word readback", {16'h0, r}, 32'hBEEF);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule